// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block runs one read or one write cycle on the common memory space of a NAND Flash device. It counts every phase in controller clocks. The phase lengths come from a 32-bit timing word with four 8-bit fields, held in a small register inside the block. A load pulse replaces the word, and reset sets it to 0xFCFCFCFC. For each access, the block drives these pins:

- an address-valid qualifier and the address;
- an active-low read strobe or an active-low write strobe;
- a data-output enable and the write data.

It samples an active-low wait input from the device. It returns read data with a one-cycle response pulse.

Requests arrive on a valid/ready channel. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the sequencer is idle. It falls on the edge after acceptance and stays low until the response cycle. A requester that finds `req_ready` low must hold its request and wait. The response channel has no ready input. `rsp_valid` is a single-cycle pulse that cannot be stalled, so the requester must take it when it appears. The timing word and the request fields are captured when the request is accepted.

Top module: `nand_access_seq`

## Requirements
- R1: After reset, both strobes are high and `mem_addr_vld`, `mem_dq_oe` and `rsp_valid` are low. `req_ready` is high. The timing word is 0xFCFCFCFC. Its fields are setup in bits 7:0 (S), wait in bits 15:8 (W), hold in bits 23:16 (H) and Hi-Z in bits 31:24 (Z).
- R2: From the cycle after acceptance, `mem_addr_vld` is high with both strobes high for exactly S+1 cycles before the strobe asserts.
- R3: A read asserts only `mem_oe_n` and a write asserts only `mem_we_n`. The two strobes are never low together.
- R4: With the wait input high, the strobe stays low for exactly W+1 cycles.
- R5: The wait input goes through a two-stage synchronizer. A rise of `mem_wait_n` set up before the edge that ends strobe cycle L is acted on two cycles later. When the input is low at the end of the programmed count, the strobe therefore lasts max(W+1, L+2) cycles.
- R6: After the strobe rises, `mem_addr_vld` stays high for H cycles on a write and H+1 cycles on a read. `mem_addr` equals the request address and does not change for the whole access.
- R7: On a write, `mem_dq_oe` first rises in cycle Z, where cycle 0 is the first setup cycle. It stays high until the access ends, and `mem_dq_out` equals the write data while it is high. If the access is shorter than Z cycles, `mem_dq_oe` never rises.
- R8: On a read, `mem_dq_oe` is never high.
- R9: `rsp_valid` is high for exactly one cycle: the first cycle after the last hold cycle. On a read, `rsp_rdata` holds `mem_dq_in` as sampled on the edge that ended the last strobe-low cycle.
- R10: `req_ready` is low from the cycle after acceptance through the last hold cycle. It is high again in the response cycle.
- R11: A load of the timing word during an access does not change that access. It sets the timing of the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Replace the timing word with `cfg_value` |
| cfg_value | input | 32 | New timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr_vld | output | 1 | Address phase active |
| mem_addr | output | ADDR_W | Address to device |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_out | output | DATA_W | Data to device |
| mem_dq_in | input | DATA_W | Data from device |
| mem_wait_n | input | 1 | Active-low wait from device |

## Verification
A phase counter loaded with the wrong value shows up at once at the pins. The strobe edge moves relative to the rise of `mem_addr_vld`, or the response pulse moves relative to the strobe rise, by the counting error within the same access. A direction latched wrongly shows a wrong strobe or a data enable on a read, within S+1 cycles of acceptance. A synchronizer with the wrong depth changes the strobe-low length in the extended cycle by the missing or extra stage. Read data captured on the wrong edge returns the inverted value, because the stimulus inverts `mem_dq_in` one cycle after the strobe rises. A timing word latched late shows the new field lengths in the access where the word was loaded.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int FIELD_W = 8;
  localparam int CFG_W   = 4 * FIELD_W;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'hFCFC_FCFC;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_COMMAND,
    ST_WAIT_EXT,
    ST_HOLD
  } seq_state_e;

  // Field layout of the timing word; the first member lands in the MSBs.
  typedef struct packed {
    logic [FIELD_W-1:0] hiz;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] wt;
    logic [FIELD_W-1:0] setup;
  } tim_fields_t;

endpackage

// File: rtl/nand_cfg_reg.sv
module nand_cfg_reg
  import nand_seq_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CFG_W-1:0]  value,
  output tim_fields_t       fields
);

  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= RESET_VAL;
    else if (load) word_q <= value;
  end

  assign fields = tim_fields_t'(word_q);

endmodule

// File: rtl/nand_wait_sync.sv
module nand_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n_async,
  output logic ready_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= wait_n_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], wait_n_async};
      end
    end
  endgenerate

  assign ready_sync = chain_q[STAGES-1];

endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_write,
  input  tim_fields_t fields,
  input  logic        wait_ready,
  output logic        busy,
  output logic        cmd_on,
  output logic        is_write,
  output logic        cmd_end,
  output logic        acc_end,
  output logic        drive_ok
);

  localparam int CW = FIELD_W + 1;

  seq_state_e         state_q;
  logic [CW-1:0]      cnt_q;
  logic [FIELD_W-1:0] hiz_q;
  logic [FIELD_W-1:0] wt_q;
  logic [FIELD_W-1:0] hold_q;
  logic               wr_q;
  logic [CW-1:0]      hold_len;

  // Reads hold one cycle longer than writes.
  assign hold_len = {1'b0, hold_q} + CW'(!wr_q);

  assign cmd_end = ((state_q == ST_COMMAND) && (cnt_q == '0) && wait_ready) ||
                   ((state_q == ST_WAIT_EXT) && wait_ready);
  assign acc_end = (cmd_end && (hold_len == '0)) ||
                   ((state_q == ST_HOLD) && (cnt_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wt_q    <= '0;
      hold_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          wt_q    <= fields.wt;
          hold_q  <= fields.hold;
          wr_q    <= start_write;
          cnt_q   <= {1'b0, fields.setup};
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            cnt_q   <= {1'b0, wt_q};
            state_q <= ST_COMMAND;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_COMMAND, ST_WAIT_EXT: begin
          if (cmd_end) begin
            cnt_q   <= hold_len - CW'(1);
            state_q <= (hold_len == '0) ? ST_IDLE : ST_HOLD;
          end else if (state_q == ST_COMMAND) begin
            if (cnt_q == '0) state_q <= ST_WAIT_EXT;
            else             cnt_q   <= cnt_q - CW'(1);
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Hi-Z window counts from the first setup cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hiz_q <= '0;
    else if (start && !busy)             hiz_q <= fields.hiz;
    else if (busy && (hiz_q != '0))      hiz_q <= hiz_q - FIELD_W'(1);
  end

  assign busy     = (state_q != ST_IDLE);
  assign cmd_on   = (state_q == ST_COMMAND) || (state_q == ST_WAIT_EXT);
  assign is_write = wr_q;
  assign drive_ok = busy && wr_q && (hiz_q == '0);

  AST_CMD_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMMAND && $past(state_q) != ST_COMMAND) |-> ($past(state_q) == ST_SETUP)); // R2
  AST_EXT_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_EXT && $past(state_q) == ST_COMMAND) |-> !$past(wait_ready)); // R5
  AST_HOLD_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q) != ST_HOLD) |-> ($past(state_q) == ST_COMMAND || $past(state_q) == ST_WAIT_EXT)); // R6

endmodule

// File: rtl/nand_access_seq.sv
module nand_access_seq
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CFG_W-1:0]  cfg_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_addr_vld,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_wait_n
);

  tim_fields_t       fields;
  logic              wait_ready;
  logic              busy, cmd_on, is_write, cmd_end, acc_end, drive_ok;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  nand_cfg_reg #(.RESET_VAL(CFG_RESET)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .value  (cfg_value),
    .fields (fields)
  );

  nand_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_n_async (mem_wait_n),
    .ready_sync   (wait_ready)
  );

  nand_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_write (req_write),
    .fields      (fields),
    .wait_ready  (wait_ready),
    .busy        (busy),
    .cmd_on      (cmd_on),
    .is_write    (is_write),
    .cmd_end     (cmd_end),
    .acc_end     (acc_end),
    .drive_ok    (drive_ok)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rdata_q <= '0;
    else if (cmd_end && !is_write) rdata_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= acc_end;
  end

  assign rsp_valid    = rsp_q;
  assign rsp_rdata    = rdata_q;
  assign mem_addr_vld = busy;
  assign mem_addr     = addr_q;
  assign mem_we_n     = !(cmd_on && is_write);
  assign mem_oe_n     = !(cmd_on && !is_write);
  assign mem_dq_oe    = drive_ok;
  assign mem_dq_out   = wdata_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R3
  AST_STROBE_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> mem_addr_vld); // R2
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_vld && $past(mem_addr_vld)) |-> $stable(mem_addr)); // R6

endmodule

// File: tb/test_nand_access_seq.sv
`timescale 1ns/1ps
module test_nand_access_seq;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int WATCHDOG_NS = 900_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [31:0]   cfg_value = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_addr_vld;
  logic [AW-1:0] mem_addr;
  logic          mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;
  logic          mem_wait_n = 1'b1;

  int checks = 0;
  int fails  = 0;
  logic [31:0] cur_cfg = 32'hFCFC_FCFC;

  always #2.5 clk = ~clk;

  nand_access_seq #(.ADDR_W(AW), .DATA_W(DW)) i_nand_access_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_value(cfg_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr_vld(mem_addr_vld), .mem_addr(mem_addr),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_wait_n(mem_wait_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_strobe(input int w, input int l);
    int e = w + 1;
    if (l > 0 && l + 2 > e) e = l + 2;
    return e;
  endfunction

  task automatic load_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_load = 1'b1; cfg_value = v;
    @(negedge clk);
    cfg_load = 1'b0;
    cur_cfg = v;
  endtask

  // l: strobe-low cycle after which the wait input is released; 0 = never held
  task automatic do_access(input bit wr, input int l, input bit reload, input logic [31:0] nxt);
    int s = int'(cur_cfg[7:0]);
    int w = int'(cur_cfg[15:8]);
    int h = int'(cur_cfg[23:16]);
    int z = int'(cur_cfg[31:24]);
    logic [AW-1:0] a = AW'($urandom);
    logic [DW-1:0] wd = DW'($urandom);
    logic [DW-1:0] rd = DW'($urandom);
    int idx = 0, set_c = 0, st_c = 0, hold_c = 0, busy_c = 0;
    int first_oe = -1, oe_c = 0, bad_str = 0, bad_addr = 0, bad_dat = 0, bad_rdy = 0;
    int rsp_idx = -1, t, exp_st, exp_h, exp_oe_first, exp_oe_c;
    bit strobe_low, wrong_low;
    logic [DW-1:0] got_rd = '0;
    if (l > 0) begin
      mem_wait_n = 1'b0;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    mem_dq_in = ~rd;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a;
    if (reload) begin cfg_load = 1'b1; cfg_value = nxt; end
    while (idx < 3000) begin
      strobe_low = wr ? !mem_we_n : !mem_oe_n;
      wrong_low  = wr ? !mem_oe_n : !mem_we_n;
      if (wrong_low) bad_str++;
      if (rsp_valid) begin
        rsp_idx = idx; got_rd = rsp_rdata;
        if (mem_addr_vld || !req_ready) bad_rdy++;
        break;
      end
      if (!mem_addr_vld) break;
      busy_c++;
      if (req_ready) bad_rdy++;
      if (mem_addr != a) bad_addr++;
      if (strobe_low) begin
        st_c++;
        mem_dq_in = rd;
        if (st_c == l) mem_wait_n = 1'b1;
      end else if (st_c == 0) set_c++;
      else begin hold_c++; mem_dq_in = ~rd; end
      if (mem_dq_oe) begin
        if (first_oe < 0) first_oe = idx;
        oe_c++;
        if (mem_dq_out != wd) bad_dat++;
      end
      idx++;
      @(negedge clk);
      if (idx == 1 && reload) cfg_load = 1'b0;
    end
    if (st_c == 0) mem_dq_in = ~rd;
    mem_wait_n = 1'b1;
    exp_st = exp_strobe(w, l);
    exp_h  = wr ? h : h + 1;
    t = s + 1 + exp_st + exp_h;
    exp_oe_first = (wr && z < t) ? z : -1;
    exp_oe_c     = (wr && z < t) ? t - z : 0;
    chk(set_c == s + 1, "R2 setup cycles", set_c, s + 1);
    chk(st_c == exp_st, (l > 0) ? "R5 extended strobe" : "R4 strobe cycles", st_c, exp_st);
    chk(bad_str == 0, "R3 strobe selection", bad_str, 0);
    chk(hold_c == exp_h, "R6 hold cycles", hold_c, exp_h);
    chk(bad_addr == 0, "R6 address stable", bad_addr, 0);
    if (wr) begin
      chk(first_oe == exp_oe_first, "R7 hi-z end", first_oe, exp_oe_first);
      chk(oe_c == exp_oe_c, "R7 drive cycles", oe_c, exp_oe_c);
      chk(bad_dat == 0, "R7 write data", bad_dat, 0);
    end else begin
      chk(oe_c == 0, "R8 no drive on read", oe_c, 0);
      chk(got_rd == rd, "R9 read data", int'(got_rd), int'(rd));
    end
    chk(rsp_idx == t, "R9 response cycle", rsp_idx, t);
    chk(bad_rdy == 0, "R10 ready low while busy", bad_rdy, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 single pulse", int'(rsp_valid), 0);
    if (reload) cur_cfg = nxt;
  endtask

  initial begin
    #(WATCHDOG_NS);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_we_n && mem_oe_n, "R1 strobes high", int'({mem_we_n, mem_oe_n}), 3);
    chk(!mem_addr_vld && !mem_dq_oe && !rsp_valid, "R1 outputs low",
        int'({mem_addr_vld, mem_dq_oe, rsp_valid}), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    // R1 reset timing word drives the first access
    do_access(1'b1, 0, 1'b0, '0);
    do_access(1'b0, 0, 1'b0, '0);
    // all-zero fields
    load_cfg(32'h0000_0000);
    do_access(1'b1, 0, 1'b0, '0);
    do_access(1'b0, 0, 1'b0, '0);
    // Hi-Z longer than the access (R7)
    load_cfg(32'h3201_0101);
    do_access(1'b1, 0, 1'b0, '0);
    // wait extension (R5) and a release that arrives before the count ends
    load_cfg(32'h0202_0001);
    do_access(1'b1, 1, 1'b0, '0);
    do_access(1'b0, 6, 1'b0, '0);
    load_cfg(32'h0101_0A01);
    do_access(1'b0, 5, 1'b0, '0);
    // R11 reload during an access
    load_cfg(32'h0302_0403);
    do_access(1'b1, 0, 1'b1, 32'h0001_0200);
    do_access(1'b1, 0, 1'b0, '0);
    for (int n = 0; n < 40; n++) begin
      logic [31:0] c;
      c = {8'($urandom_range(0, 14)), 8'($urandom_range(0, 6)),
           8'($urandom_range(0, 6)), 8'($urandom_range(0, 6))};
      load_cfg(c);
      do_access(1'($urandom), ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 10)),
                1'($urandom), {8'($urandom_range(0, 9)), 8'($urandom_range(0, 5)),
                               8'($urandom_range(0, 5)), 8'($urandom_range(0, 5))});
      do_access(1'($urandom), 0, 1'b0, '0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule